// File: doc/BRIEF.md
# GPIO Bank with Interrupt Logic

This block is a bank of up to 32 general purpose pins behind a simple word-wide register interface. For each pin, software picks the direction, the value driven when the pin is an output, whether that value blinks, and whether the sampled input is inverted. Every input is brought into the clock domain by a two-flop synchronizer and then XORed with its polarity bit. The result is readable as the pin value register.

Interrupts come from two sources. A level source is the polarity-adjusted pin value itself. An edge source is a sticky cause bit that is set when that adjusted value rises. With polarity 0 this means a rising line, and with polarity 1 it means a falling line. Each source has its own mask. Software clears cause bits by writing a word that holds zeros in the bit positions it wants to clear.

The per-pin interrupts are ORed in groups of eight pins onto four summary lines. A parameter sets how many pins exist. Bits for pins that do not exist read as zero and never raise an interrupt. A free-running divider, shared by all pins, provides the blink phase.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset every implemented pin is an input (direction reads 1 and `pin_oe` is 0). The output, blink, polarity, both masks and the edge cause all read 0, and `irq_grp` is 0.
- R2: Registers are selected by the word index `addr`: 0 direction, 1 output value, 2 blink enable, 3 polarity, 4 level mask, 5 edge mask, 6 edge cause, 7 pin value. Writable registers read back what was written, and bits at or above NPINS read as 0.
- R3: A direction bit of 0 makes the pin an output (`pin_oe` bit 1). A direction bit of 1 makes it an input (`pin_oe` bit 0).
- R4: The pin value register (index 7) reads each pin after two synchronizer flops, XORed with its polarity bit. Writes to index 7 have no effect.
- R5: An edge cause bit is set when the polarity-adjusted pin value goes from 0 to 1. With polarity 0 this is a rising line and with polarity 1 a falling line. A change of the polarity bit that raises the adjusted value also counts as an edge.
- R6: A write to the edge cause register clears every cause bit written as 0 and keeps every bit written as 1.
- R7: If an edge sets a cause bit in the same cycle as a write clears that bit, the bit ends up set.
- R8: The per-pin interrupt is (pin value AND level mask) OR (edge cause AND edge mask). `irq_grp[g]` is the OR of pins 8g to 8g+7. Groups that hold no implemented pin stay 0.
- R9: For an output whose blink bit is set, `pin_out` is the output bit XOR a shared phase that toggles every BLINK_HALF cycles, so all blinking pins stay in step. Pins without blink drive the output bit unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the register selected by `addr` |
| addr | input | 3 | Register word index |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data of the register selected by `addr` (combinational) |
| pin_in | input | 32 | Raw pin levels, asynchronous |
| pin_out | output | 32 | Value driven on each pin |
| pin_oe | output | 32 | Output enable per pin |
| irq_grp | output | 4 | Summary interrupts, one per group of eight pins |

## Verification
The clocked properties assume that the bus makes at most one write per cycle and that reset is held long enough to clear the synchronizer. They also assume that a pin held high through reset may legitimately produce one edge once reset is released. The stimulus keeps pins low during reset. After each pin change or polarity write, it leaves at least four idle cycles so that every transition has passed the synchronizer and the edge register before the expected cause is compared. The one deliberate exception is the same-cycle set and clear case, which issues the polarity write and the clearing write on consecutive edges.

// File: rtl/gpio_bank_pkg.sv
`timescale 1ns/1ps
package gpio_bank_pkg;
   localparam int unsigned MAX_PINS = 32;
   localparam int unsigned GRP_W    = 8;
   localparam int unsigned NUM_GRP  = MAX_PINS / GRP_W;
   localparam int unsigned IDX_W    = 3;

   typedef enum logic [IDX_W-1:0] {
      SEL_DIR   = 3'd0,
      SEL_OUT   = 3'd1,
      SEL_BLINK = 3'd2,
      SEL_POL   = 3'd3,
      SEL_LMASK = 3'd4,
      SEL_EMASK = 3'd5,
      SEL_CAUSE = 3'd6,
      SEL_PINS  = 3'd7
   } reg_sel_e;

   // ones in the low n bit positions
   function automatic logic [MAX_PINS-1:0] impl_bits(input int unsigned n);
      logic [MAX_PINS-1:0] m;
      m = '0;
      for (int unsigned i = 0; i < MAX_PINS; i++) begin
         if (i < n) m[i] = 1'b1;
      end
      return m;
   endfunction
endpackage

// File: rtl/gpio_sync.sv
`timescale 1ns/1ps
module gpio_sync #(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] meta_q;
   logic [W-1:0] stable_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         meta_q   <= '0;
         stable_q <= '0;
      end else begin
         meta_q   <= d;
         stable_q <= meta_q;
      end
   end

   assign q = stable_q;
endmodule

// File: rtl/gpio_blink_div.sv
`timescale 1ns/1ps
module gpio_blink_div #(
   parameter int unsigned HALF = 4
) (
   input  logic clk,
   input  logic rst_n,
   output logic phase
);
   localparam int unsigned CW   = (HALF > 1) ? $clog2(HALF) : 1;
   localparam logic [CW-1:0] LAST = CW'(HALF - 1);

   logic [CW-1:0] cnt_q;
   logic          phase_q;
   logic          wrap;

   generate
      if (HALF < 1) begin : g_bad_half
         $error("gpio_blink_div: HALF must be at least 1");
      end
   endgenerate

   assign wrap = (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         phase_q <= 1'b0;
      end else if (wrap) begin
         cnt_q   <= '0;
         phase_q <= ~phase_q;
      end else begin
         cnt_q   <= cnt_q + 1'b1;
      end
   end

   assign phase = phase_q;
endmodule

// File: rtl/gpio_irq_unit.sv
`timescale 1ns/1ps
module gpio_irq_unit
   import gpio_bank_pkg::*;
#(
   parameter int unsigned NPINS = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [MAX_PINS-1:0] din,
   input  logic                cause_wr,
   input  logic [MAX_PINS-1:0] wdata,
   input  logic [MAX_PINS-1:0] lmask,
   input  logic [MAX_PINS-1:0] emask,
   output logic [MAX_PINS-1:0] cause,
   output logic [NUM_GRP-1:0]  irq_grp
);
   localparam logic [MAX_PINS-1:0] IMPL = impl_bits(NPINS);

   logic [MAX_PINS-1:0] prev_q;
   logic [MAX_PINS-1:0] cause_q;
   logic [MAX_PINS-1:0] edge_hit;
   logic [MAX_PINS-1:0] kept;
   logic [MAX_PINS-1:0] pin_irq;

   assign edge_hit = din & ~prev_q & IMPL;
   assign kept     = cause_wr ? (cause_q & wdata) : cause_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q  <= '0;
         cause_q <= '0;
      end else begin
         prev_q  <= din & IMPL;
         cause_q <= (kept | edge_hit) & IMPL;
      end
   end

   assign cause   = cause_q;
   assign pin_irq = ((din & lmask) | (cause_q & emask)) & IMPL;

   generate
      for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
         if (g * GRP_W < NPINS) begin : g_live
            assign irq_grp[g] = |pin_irq[g*GRP_W +: GRP_W];
         end else begin : g_dead
            assign irq_grp[g] = 1'b0;
         end
      end
   endgenerate

   // R6
   cause_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cause_wr |=> ((cause_q & $past(cause_q)) == $past(cause_q)));

   // R7
   edge_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|edge_hit) |=> ((cause_q & $past(edge_hit)) == $past(edge_hit)));

   // R8
   masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((lmask | emask) == '0) |-> (irq_grp == '0));
endmodule

// File: rtl/gpio_irq_bank.sv
`timescale 1ns/1ps
module gpio_irq_bank
   import gpio_bank_pkg::*;
#(
   parameter int unsigned NPINS      = 32,
   parameter int unsigned BLINK_HALF = 4
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic [2:0]  addr,
   input  logic [31:0] wdata,
   output logic [31:0] rdata,
   input  logic [31:0] pin_in,
   output logic [31:0] pin_out,
   output logic [31:0] pin_oe,
   output logic [3:0]  irq_grp
);
   localparam logic [MAX_PINS-1:0] IMPL = impl_bits(NPINS);

   generate
      if (NPINS < 1 || NPINS > MAX_PINS) begin : g_bad_pins
         $error("gpio_irq_bank: NPINS must lie in 1..32");
      end
   endgenerate

   reg_sel_e            sel;
   logic [MAX_PINS-1:0] dir_q, out_q, blink_q, pol_q, lmask_q, emask_q;
   logic [MAX_PINS-1:0] sync_q;
   logic [MAX_PINS-1:0] din;
   logic [MAX_PINS-1:0] cause;
   logic [MAX_PINS-1:0] wmask;
   logic                phase;
   logic                cause_wr;

   assign sel      = reg_sel_e'(addr);
   assign wmask    = wdata & IMPL;
   assign cause_wr = wr_en && (sel == SEL_CAUSE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q   <= IMPL;
         out_q   <= '0;
         blink_q <= '0;
         pol_q   <= '0;
         lmask_q <= '0;
         emask_q <= '0;
      end else if (wr_en) begin
         case (sel)
            SEL_DIR:   dir_q   <= wmask;
            SEL_OUT:   out_q   <= wmask;
            SEL_BLINK: blink_q <= wmask;
            SEL_POL:   pol_q   <= wmask;
            SEL_LMASK: lmask_q <= wmask;
            SEL_EMASK: emask_q <= wmask;
            default:   ;
         endcase
      end
   end

   gpio_sync #(.W(MAX_PINS)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_in),
      .q     (sync_q)
   );

   assign din = (sync_q ^ pol_q) & IMPL;

   gpio_blink_div #(.HALF(BLINK_HALF)) u_blink (
      .clk   (clk),
      .rst_n (rst_n),
      .phase (phase)
   );

   gpio_irq_unit #(.NPINS(NPINS)) u_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .din      (din),
      .cause_wr (cause_wr),
      .wdata    (wdata),
      .lmask    (lmask_q),
      .emask    (emask_q),
      .cause    (cause),
      .irq_grp  (irq_grp)
   );

   always_comb begin
      case (sel)
         SEL_DIR:   rdata = dir_q;
         SEL_OUT:   rdata = out_q;
         SEL_BLINK: rdata = blink_q;
         SEL_POL:   rdata = pol_q;
         SEL_LMASK: rdata = lmask_q;
         SEL_EMASK: rdata = emask_q;
         SEL_CAUSE: rdata = cause;
         default:   rdata = din;
      endcase
   end

   assign pin_oe  = ~dir_q & IMPL;
   assign pin_out = (out_q ^ (blink_q & {MAX_PINS{phase}})) & IMPL;

   // R3
   dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && sel == SEL_DIR) |=> (pin_oe == (~$past(wdata) & IMPL)));
endmodule

// File: tb/gpio_irq_bank_test.sv
`timescale 1ns/1ps
module gpio_irq_bank_test;
   localparam int unsigned NP   = 28;
   localparam int unsigned HALF = 4;
   localparam logic [31:0] IMPL = (32'h1 << NP) - 32'h1;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  addr = 3'd0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic [31:0] pin_in = '0;
   logic [31:0] pin_out, pin_oe;
   logic [3:0]  irq_grp;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   logic [31:0] m_dir, m_out, m_blink, m_pol, m_lm, m_em, m_cause, m_pins;

   always #10 clk = ~clk;

   gpio_irq_bank #(.NPINS(NP), .BLINK_HALF(HALF)) uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
      .irq_grp(irq_grp)
   );

   function automatic logic [31:0] exp_din();
      return (m_pins ^ m_pol) & IMPL;
   endfunction

   function automatic logic [3:0] exp_grp();
      logic [31:0] p;
      logic [3:0]  g;
      p = ((exp_din() & m_lm) | (m_cause & m_em)) & IMPL;
      for (int i = 0; i < 4; i++) g[i] = |p[i*8 +: 8];
      return g;
   endfunction

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got %h exp %h", tag, got, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] v);
      addr = a;
      #1;
      v = rdata;
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      logic [31:0] old_adj;
      old_adj = exp_din();
      addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
      case (a)
         3'd0: m_dir   = d & IMPL;
         3'd1: m_out   = d & IMPL;
         3'd2: m_blink = d & IMPL;
         3'd3: begin
            m_pol = d & IMPL;
            m_cause = m_cause | (exp_din() & ~old_adj);
         end
         3'd4: m_lm    = d & IMPL;
         3'd5: m_em    = d & IMPL;
         3'd6: m_cause = m_cause & d;
         default: ;
      endcase
   endtask

   task automatic set_pins(input logic [31:0] v);
      logic [31:0] old_adj;
      old_adj = exp_din();
      pin_in = v;
      m_pins = v;
      idle(4);
      m_cause = m_cause | (exp_din() & ~old_adj);
   endtask

   task automatic check_all(input string tag);
      logic [31:0] v;
      rd(3'd0, v); chk({tag, " R2 dir"}, v, m_dir);
      rd(3'd1, v); chk({tag, " R2 out"}, v, m_out);
      rd(3'd2, v); chk({tag, " R2 blink"}, v, m_blink);
      rd(3'd3, v); chk({tag, " R2 pol"}, v, m_pol);
      rd(3'd4, v); chk({tag, " R2 lmask"}, v, m_lm);
      rd(3'd5, v); chk({tag, " R2 emask"}, v, m_em);
      rd(3'd6, v); chk({tag, " R5 cause"}, v, m_cause);
      rd(3'd7, v); chk({tag, " R4 pins"}, v, exp_din());
      chk({tag, " R3 oe"}, pin_oe, ~m_dir & IMPL);
      chk({tag, " R8 irq"}, {28'd0, irq_grp}, {28'd0, exp_grp()});
      chk({tag, " R9 steady out"}, pin_out & ~m_blink, m_out & ~m_blink);
   endtask

   initial begin
      #(20 * 150000);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      int unsigned seed;
      int trans;
      logic p0, prev0;
      seed = $urandom(32'd20240);
      m_dir = IMPL; m_out = 0; m_blink = 0; m_pol = 0; m_lm = 0; m_em = 0;
      m_cause = 0; m_pins = 0;

      // R1 reset state
      idle(5);
      rst_n = 1'b1;
      idle(2);
      check_all("R1");
      chk("R1 oe zero", pin_oe, 32'h0);
      chk("R1 irq zero", {28'd0, irq_grp}, 32'h0);

      // R2 readback and unimplemented bits
      wr(3'd4, 32'hFFFF_FFFF);
      rd(3'd4, v); chk("R2 lmask upper bits zero", v, 32'h0FFF_FFFF);
      wr(3'd4, 32'h0);
      wr(3'd1, 32'hA5A5_5A5A);
      check_all("R2");

      // R4 write to pin value ignored
      set_pins(32'h0000_1234);
      wr(3'd7, 32'hFFFF_FFFF);
      rd(3'd7, v); chk("R4 pin value write ignored", v, 32'h0000_1234);
      wr(3'd6, 32'h0);

      // R3 direction
      wr(3'd0, 32'hFFFF_FF0F);
      chk("R3 outputs on pins 4..7", pin_oe, 32'h0000_00F0);
      wr(3'd0, IMPL);

      // R5 rising with polarity 0, falling with polarity 1
      set_pins(32'h0);
      wr(3'd6, 32'h0);
      set_pins(32'h1);
      rd(3'd6, v); chk("R5 rising line sets cause0", v, 32'h1);
      wr(3'd3, 32'h2);
      idle(2);
      rd(3'd6, v); chk("R5 polarity flip raises adjusted value", v, 32'h3);
      wr(3'd6, 32'h0);
      set_pins(32'h3);
      rd(3'd6, v); chk("R5 rising line with polarity 1 no edge", v, 32'h0);
      set_pins(32'h1);
      rd(3'd6, v); chk("R5 falling line with polarity 1 sets cause1", v, 32'h2);

      // R6 write-zero acknowledge
      set_pins(32'h0);
      wr(3'd3, 32'h0);
      set_pins(32'h0000_00F0);
      rd(3'd6, v); chk("R6 four causes pending", v, 32'h0000_00F2);
      wr(3'd6, 32'hFFFF_FF5F);
      idle(1);
      rd(3'd6, v); chk("R6 zero bits cleared, one bits kept", v, 32'h0000_0052);

      // R7 set and clear in the same cycle
      set_pins(32'h0);
      wr(3'd6, 32'h0);
      set_pins(32'h8);
      wr(3'd3, 32'h20);
      wr(3'd6, 32'h0);
      m_cause = 32'h20;
      idle(2);
      rd(3'd6, v); chk("R7 new edge beats clear", v, 32'h20);
      wr(3'd3, 32'h0);
      wr(3'd6, 32'h0);
      set_pins(32'h0);

      // R8 group reduction, last group partial
      wr(3'd4, 32'h0800_0000);
      set_pins(32'h0800_0000);
      chk("R8 pin 27 drives group 3", {28'd0, irq_grp}, 32'h8);
      wr(3'd4, 32'h0);
      wr(3'd5, 32'h0000_0100);
      wr(3'd6, 32'h0);
      set_pins(32'h0000_0100);
      chk("R8 masked edge on pin 8 drives group 1", {28'd0, irq_grp}, 32'h2);
      set_pins(32'hF000_0000);
      chk("R8 pins above NPINS raise nothing", {28'd0, irq_grp}, {28'd0, exp_grp()});
      wr(3'd5, 32'h0);

      // R9 blink
      wr(3'd0, IMPL & ~32'hF);
      wr(3'd1, 32'h5);
      wr(3'd2, 32'h3);
      trans = 0;
      prev0 = pin_out[0];
      for (int k = 0; k < 8; k++) begin
         idle(1);
         p0 = pin_out[0];
         if (p0 != prev0) trans++;
         prev0 = p0;
         chk("R9 blinking pins in step", {31'd0, pin_out[0] ^ pin_out[1]}, 32'h1);
         chk("R9 non-blink pins steady", pin_out & 32'hC, 32'h4);
      end
      chk("R9 toggles per 2*HALF cycles", trans, 2);
      wr(3'd2, 32'h0);

      // random traffic
      for (int it = 0; it < 400; it++) begin
         int op;
         op = $urandom_range(0, 9);
         if (op < 4) set_pins($urandom());
         else if (op < 6) wr(3'd6, $urandom() | $urandom());
         else wr(3'($urandom_range(0, 7)), $urandom());
         idle(4);
         check_all("RND");
      end

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule